// File: doc/BRIEF.md
# UART In-Band Pause/Resume Controller

This block sits next to a UART receiver and transmitter and runs software (in-band) flow control. Every byte the receiver delivers passes through it. The byte is compared with four programmable control characters: two resume characters (on1, on2) and two pause characters (off1, off2). The block either consumes the byte as a control character or hands it on to the receive FIFO. A matched pause character raises `tx_pause`, which tells the local transmitter to stop at its next character boundary. A matched resume character drops `tx_pause` again.

On the transmit side, the block watches the receive FIFO fill level. When the level reaches the high threshold, it raises a one-cycle request that asks the transmitter to send the selected pause character(s). When the level later falls to the low threshold, it raises one request for the resume character(s). The transmitter sends these ahead of normal data.

A separate detect mode turns off normal flow control. In this mode each received byte is compared with off2 alone. A matching byte is kept as data and sets a sticky interrupt flag.

Top module: `uart_swflow`

## Requirements
- R1: After reset, all outputs are low. With the mode field at 0000 and detect mode off, every received byte appears unchanged on `fwd_byte` with `fwd_vld` high in the cycle after its `rx_vld` strobe.
- R2: Receive field `fc_mode[1:0]`=10 compares with on1/off1, and 01 compares with on2/off2. A matching pause byte sets `tx_pause` and a matching resume byte clears it. Either byte is consumed (no `fwd_vld`), and the effect appears in the cycle after the strobe. Other bytes are forwarded, and `tx_pause` keeps its value.
- R3: A byte matches a character only when all bits are equal, with bit 0 of the character against the least significant bit of the received byte. For example, 8'hC8 does not match a character of 8'h13.
- R4: Receive field 11 combined with transmit field `fc_mode[3:2]`=00 is treated as no receive flow control, so all bytes are forwarded.
- R5: In dual mode (receive field 11 with a non-zero transmit field), pausing needs off1 followed by off2 as the next received byte, and resuming needs on1 followed by on2. Both bytes are consumed.
- R6: In dual mode, if a byte other than the expected second character follows a pending first character, the pending byte is forwarded in the cycle after that strobe. The new byte is forwarded one cycle later, unless it is itself on1 or off1, in which case it becomes the new pending byte.
- R7: Whenever the effective receive mode is none, `tx_pause` is cleared at the next edge.
- R8: With `spec_en` high, flow control is off, every byte is forwarded, and a byte equal to off2 sets `spec_irq` in the cycle after its strobe.
- R9: `spec_irq` stays high until a `spec_clr` strobe. If a match and a clear arrive in the same cycle, the flag stays set.
- R10: With a non-zero transmit field, the level reaching `rxq_hi` gives a single one-cycle `ins_req` with `ins_xoff`=1. A later level at or below `rxq_lo` gives a single `ins_req` with `ins_xoff`=0. `ins_sel` equals the transmit field: bit 1 means pair 1 and bit 0 means pair 2. With transmit field 00 (or `spec_en` high), no request is made.
- R11: `rx_vld` strobes are at least one idle cycle apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fc_mode | input | 4 | [3:2] transmit field, [1:0] receive field |
| spec_en | input | 1 | Off2 detect mode enable |
| on1_chr | input | DW | Resume character, pair 1 |
| on2_chr | input | DW | Resume character, pair 2 |
| off1_chr | input | DW | Pause character, pair 1 |
| off2_chr | input | DW | Pause character, pair 2 |
| rx_byte | input | DW | Byte from the UART receiver |
| rx_vld | input | 1 | One-cycle strobe for rx_byte |
| spec_clr | input | 1 | Clears spec_irq |
| rxq_level | input | LW | Receive FIFO fill level |
| rxq_hi | input | LW | Pause-request threshold |
| rxq_lo | input | LW | Resume-request threshold |
| fwd_vld | output | 1 | Byte for the receive FIFO is valid |
| fwd_byte | output | DW | Byte for the receive FIFO |
| tx_pause | output | 1 | Hold the transmitter |
| spec_irq | output | 1 | Off2 detected flag |
| ins_req | output | 1 | One-cycle insert request to the transmitter |
| ins_xoff | output | 1 | 1 = pause characters, 0 = resume characters |
| ins_sel | output | 2 | Pairs to send: bit 1 pair 1, bit 0 pair 2 |

## Verification
The assertions check these rules on every cycle:
- a pause or resume event moves `tx_pause` in the next cycle, and a none receive mode clears it;
- the detect flag sets on an off2 match, holds, and clears only on a clear that has no competing match;
- no insert request appears while the transmit mode is none;
- bytes pass straight through when no comparison is active.

Other behaviours need ordered byte streams, and only the bench scenarios can show them:
- the two-byte sequences of dual mode and what happens to a broken pair;
- the bit-order check of the comparison;
- the rule that receive mode 11 is invalid without a transmit mode;
- the hysteresis between the two fill thresholds.

// File: rtl/swflow_pkg.sv
package swflow_pkg;

  localparam logic [1:0] SEL_NONE = 2'b00;
  localparam logic [1:0] SEL_P2   = 2'b01;
  localparam logic [1:0] SEL_P1   = 2'b10;
  localparam logic [1:0] SEL_BOTH = 2'b11;

  localparam int I_ON1  = 0;
  localparam int I_ON2  = 1;
  localparam int I_OFF1 = 2;
  localparam int I_OFF2 = 3;
  localparam int NCHR   = 4;

  // transmit field; forced off while the off2 detect mode runs
  function automatic logic [1:0] eff_tx(input logic [3:0] m, input logic spec);
    return spec ? SEL_NONE : m[3:2];
  endfunction

  // receive field; the "both pairs" code needs a transmit mode (R4)
  function automatic logic [1:0] eff_rx(input logic [3:0] m, input logic spec);
    if (spec) return SEL_NONE;
    if (m[1:0] == SEL_BOTH && m[3:2] == SEL_NONE) return SEL_NONE;
    return m[1:0];
  endfunction

endpackage

// File: rtl/swflow_rx.sv
module swflow_rx
  import swflow_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rx_mode,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_vld,
  input  logic [DW-1:0] on1_chr,
  input  logic [DW-1:0] on2_chr,
  input  logic [DW-1:0] off1_chr,
  input  logic [DW-1:0] off2_chr,
  output logic          fwd_vld,
  output logic [DW-1:0] fwd_byte,
  output logic          tx_pause,
  output logic          ev_xoff,
  output logic          ev_xon
);

  logic [DW-1:0] chr_tab [NCHR];
  logic [NCHR-1:0] hit;

  assign chr_tab[I_ON1]  = on1_chr;
  assign chr_tab[I_ON2]  = on2_chr;
  assign chr_tab[I_OFF1] = off1_chr;
  assign chr_tab[I_OFF2] = off2_chr;

  // full-width compare, bit 0 against the received LSB (R3)
  for (genvar gi = 0; gi < NCHR; gi++) begin : g_cmp
    assign hit[gi] = (rx_byte == chr_tab[gi]);
  end

  logic          pend_vld, pend_off;
  logic [DW-1:0] pend_byte;
  logic          hold_vld;
  logic [DW-1:0] hold_byte;
  logic          set_pend, flush, pass;

  always_comb begin
    ev_xoff  = 1'b0;
    ev_xon   = 1'b0;
    set_pend = 1'b0;
    flush    = 1'b0;
    pass     = 1'b0;
    if (rx_vld) begin
      case (rx_mode)
        SEL_P1: begin
          if (hit[I_OFF1])     ev_xoff = 1'b1;
          else if (hit[I_ON1]) ev_xon  = 1'b1;
          else                 pass    = 1'b1;
        end
        SEL_P2: begin
          if (hit[I_OFF2])     ev_xoff = 1'b1;
          else if (hit[I_ON2]) ev_xon  = 1'b1;
          else                 pass    = 1'b1;
        end
        SEL_BOTH: begin
          if (pend_vld && pend_off && hit[I_OFF2])       ev_xoff = 1'b1;
          else if (pend_vld && !pend_off && hit[I_ON2])  ev_xon  = 1'b1;
          else begin
            flush = pend_vld;                    // broken pair (R6)
            if (hit[I_OFF1] || hit[I_ON1]) set_pend = 1'b1;
            else                           pass     = 1'b1;
          end
        end
        default: pass = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_pause  <= 1'b0;
      pend_vld  <= 1'b0;
      pend_off  <= 1'b0;
      pend_byte <= '0;
      hold_vld  <= 1'b0;
      hold_byte <= '0;
      fwd_vld   <= 1'b0;
      fwd_byte  <= '0;
    end else begin
      if (rx_mode == SEL_NONE) tx_pause <= 1'b0;
      else if (ev_xoff)        tx_pause <= 1'b1;
      else if (ev_xon)         tx_pause <= 1'b0;

      if (rx_mode != SEL_BOTH) pend_vld <= 1'b0;
      else if (rx_vld)         pend_vld <= set_pend;
      if (set_pend) begin
        pend_byte <= rx_byte;
        pend_off  <= hit[I_OFF1];
      end

      hold_vld <= flush && pass;
      if (flush && pass) hold_byte <= rx_byte;

      if (flush) begin
        fwd_vld  <= 1'b1;
        fwd_byte <= pend_byte;
      end else if (pass) begin
        fwd_vld  <= 1'b1;
        fwd_byte <= rx_byte;
      end else if (hold_vld) begin
        fwd_vld  <= 1'b1;
        fwd_byte <= hold_byte;
      end else begin
        fwd_vld  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/swflow_tx.sv
module swflow_tx
  import swflow_pkg::*;
#(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    tx_sel,
  input  logic [LW-1:0] lvl,
  input  logic [LW-1:0] thr_hi,
  input  logic [LW-1:0] thr_lo,
  output logic          ins_req,
  output logic          ins_xoff,
  output logic [1:0]    ins_sel
);

  logic xoff_sent;
  logic ev_hi, ev_lo;

  assign ev_hi = (tx_sel != SEL_NONE) && !xoff_sent && (lvl >= thr_hi);
  assign ev_lo = (tx_sel != SEL_NONE) &&  xoff_sent && (lvl <= thr_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_sent <= 1'b0;
      ins_req   <= 1'b0;
      ins_xoff  <= 1'b0;
      ins_sel   <= SEL_NONE;
    end else begin
      if (tx_sel == SEL_NONE) xoff_sent <= 1'b0;
      else if (ev_hi)         xoff_sent <= 1'b1;
      else if (ev_lo)         xoff_sent <= 1'b0;
      ins_req  <= ev_hi || ev_lo;
      ins_xoff <= ev_hi;
      ins_sel  <= (ev_hi || ev_lo) ? tx_sel : SEL_NONE;
    end
  end

endmodule

// File: rtl/swflow_flag.sv
module swflow_flag #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spec_en,
  input  logic          rx_vld,
  input  logic [DW-1:0] rx_byte,
  input  logic [DW-1:0] off2_chr,
  input  logic          spec_clr,
  output logic          spec_irq
);

  logic ev_spec;
  assign ev_spec = spec_en && rx_vld && (rx_byte == off2_chr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        spec_irq <= 1'b0;
    else if (ev_spec)  spec_irq <= 1'b1;   // match beats clear (R9)
    else if (spec_clr) spec_irq <= 1'b0;
  end

endmodule

// File: rtl/uart_swflow.sv
module uart_swflow
  import swflow_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    fc_mode,
  input  logic          spec_en,
  input  logic [DW-1:0] on1_chr,
  input  logic [DW-1:0] on2_chr,
  input  logic [DW-1:0] off1_chr,
  input  logic [DW-1:0] off2_chr,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_vld,
  input  logic          spec_clr,
  input  logic [LW-1:0] rxq_level,
  input  logic [LW-1:0] rxq_hi,
  input  logic [LW-1:0] rxq_lo,
  output logic          fwd_vld,
  output logic [DW-1:0] fwd_byte,
  output logic          tx_pause,
  output logic          spec_irq,
  output logic          ins_req,
  output logic          ins_xoff,
  output logic [1:0]    ins_sel
);

  logic [1:0] rx_mode, tx_sel;
  logic       rx_none, tx_none;
  logic       ev_xoff, ev_xon;

  assign rx_mode = eff_rx(fc_mode, spec_en);
  assign tx_sel  = eff_tx(fc_mode, spec_en);
  assign rx_none = (rx_mode == SEL_NONE);
  assign tx_none = (tx_sel == SEL_NONE);

  swflow_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode),
    .rx_byte(rx_byte), .rx_vld(rx_vld),
    .on1_chr(on1_chr), .on2_chr(on2_chr),
    .off1_chr(off1_chr), .off2_chr(off2_chr),
    .fwd_vld(fwd_vld), .fwd_byte(fwd_byte), .tx_pause(tx_pause),
    .ev_xoff(ev_xoff), .ev_xon(ev_xon)
  );

  swflow_tx #(.LW(LW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
    .lvl(rxq_level), .thr_hi(rxq_hi), .thr_lo(rxq_lo),
    .ins_req(ins_req), .ins_xoff(ins_xoff), .ins_sel(ins_sel)
  );

  swflow_flag #(.DW(DW)) u_flag (
    .clk(clk), .rst_n(rst_n), .spec_en(spec_en),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .off2_chr(off2_chr),
    .spec_clr(spec_clr), .spec_irq(spec_irq)
  );

endmodule

// File: rtl/uart_swflow_chk.sv
module uart_swflow_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spec_en,
  input logic          spec_clr,
  input logic          rx_vld,
  input logic [DW-1:0] rx_byte,
  input logic [DW-1:0] off2_chr,
  input logic          rx_none,
  input logic          tx_none,
  input logic          ev_xoff,
  input logic          ev_xon,
  input logic          tx_pause,
  input logic          spec_irq,
  input logic          fwd_vld,
  input logic [DW-1:0] fwd_byte,
  input logic          ins_req,
  input logic [1:0]    ins_sel
);

  p_strobe_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_vld |=> !rx_vld);

  p_pause_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xoff |=> tx_pause);

  p_pause_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_xon |=> !tx_pause);

  p_none_unpause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_none |=> !tx_pause);

  p_pass_thru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_none && rx_vld) |=> (fwd_vld && fwd_byte == $past(rx_byte)));

  p_spec_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && rx_vld && rx_byte == off2_chr) |=> spec_irq);

  p_spec_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_en && rx_vld) |=> fwd_vld);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_irq && !spec_clr) |=> spec_irq);

  p_irq_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_clr && !(spec_en && rx_vld && rx_byte == off2_chr)) |=> !spec_irq);

  p_ins_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_none |=> !ins_req);

  p_ins_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |-> (ins_sel != 2'b00));

endmodule

bind uart_swflow uart_swflow_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spec_en(spec_en), .spec_clr(spec_clr),
  .rx_vld(rx_vld), .rx_byte(rx_byte), .off2_chr(off2_chr),
  .rx_none(rx_none), .tx_none(tx_none), .ev_xoff(ev_xoff), .ev_xon(ev_xon),
  .tx_pause(tx_pause), .spec_irq(spec_irq), .fwd_vld(fwd_vld),
  .fwd_byte(fwd_byte), .ins_req(ins_req), .ins_sel(ins_sel)
);

// File: tb/sim_uart_swflow.sv
module sim_uart_swflow;

  localparam int DW = 8;
  localparam int LW = 5;
  localparam logic [7:0] C_ON1 = 8'h11, C_OFF1 = 8'h13;
  localparam logic [7:0] C_ON2 = 8'h91, C_OFF2 = 8'h93;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] fc_mode = 4'b0000;
  logic spec_en = 1'b0, spec_clr = 1'b0, rx_vld = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic [LW-1:0] rxq_level = '0, rxq_hi = 5'd12, rxq_lo = 5'd4;
  logic fwd_vld, tx_pause, spec_irq, ins_req, ins_xoff;
  logic [DW-1:0] fwd_byte;
  logic [1:0] ins_sel;

  always #4 clk = ~clk;   // 125 MHz

  uart_swflow #(.DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .spec_en(spec_en),
    .on1_chr(C_ON1), .on2_chr(C_ON2), .off1_chr(C_OFF1), .off2_chr(C_OFF2),
    .rx_byte(rx_byte), .rx_vld(rx_vld), .spec_clr(spec_clr),
    .rxq_level(rxq_level), .rxq_hi(rxq_hi), .rxq_lo(rxq_lo),
    .fwd_vld(fwd_vld), .fwd_byte(fwd_byte), .tx_pause(tx_pause),
    .spec_irq(spec_irq), .ins_req(ins_req), .ins_xoff(ins_xoff), .ins_sel(ins_sel)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobe; returns at the first sample point after it
  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_vld = 1'b1;
    @(negedge clk); rx_vld = 1'b0;
  endtask

  function automatic logic [31:0] rx_view();
    return {22'd0, fwd_vld, (fwd_vld ? fwd_byte : 8'h00), tx_pause};
  endfunction

  function automatic logic [31:0] ins_view();
    return {28'd0, ins_req, ins_xoff, ins_sel};
  endfunction

  // req, mode, spec, byte, exp fwd, exp byte, exp pause, exp irq
  localparam int NV = 18;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1,  4'b0000, 1'b0, 8'h13, 1'b1, 8'h13, 1'b0, 1'b0}, // R1 plain
    {4'd2,  4'b0010, 1'b0, 8'h13, 1'b0, 8'h00, 1'b1, 1'b0}, // R2 off1
    {4'd2,  4'b0010, 1'b0, 8'h55, 1'b1, 8'h55, 1'b1, 1'b0}, // R2 data
    {4'd3,  4'b0010, 1'b0, 8'hC8, 1'b1, 8'hC8, 1'b1, 1'b0}, // R3 reversed bits
    {4'd2,  4'b0010, 1'b0, 8'h91, 1'b1, 8'h91, 1'b1, 1'b0}, // R2 on2 unused pair
    {4'd2,  4'b0010, 1'b0, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 on1
    {4'd2,  4'b0001, 1'b0, 8'h93, 1'b0, 8'h00, 1'b1, 1'b0}, // R2 off2
    {4'd2,  4'b0001, 1'b0, 8'h13, 1'b1, 8'h13, 1'b1, 1'b0}, // R2 off1 unused
    {4'd7,  4'b0000, 1'b0, 8'h22, 1'b1, 8'h22, 1'b0, 1'b0}, // R7 none clears
    {4'd2,  4'b0001, 1'b0, 8'h93, 1'b0, 8'h00, 1'b1, 1'b0}, // R2
    {4'd2,  4'b0001, 1'b0, 8'h91, 1'b0, 8'h00, 1'b0, 1'b0}, // R2 on2
    {4'd4,  4'b0011, 1'b0, 8'h13, 1'b1, 8'h13, 1'b0, 1'b0}, // R4 invalid combo
    {4'd5,  4'b1011, 1'b0, 8'h13, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 first
    {4'd5,  4'b1011, 1'b0, 8'h93, 1'b0, 8'h00, 1'b1, 1'b0}, // R5 pair done
    {4'd5,  4'b1011, 1'b0, 8'h11, 1'b0, 8'h00, 1'b1, 1'b0}, // R5 first
    {4'd5,  4'b1011, 1'b0, 8'h91, 1'b0, 8'h00, 1'b0, 1'b0}, // R5 resume
    {4'd8,  4'b1011, 1'b1, 8'h93, 1'b1, 8'h93, 1'b0, 1'b1}, // R8 detect
    {4'd9,  4'b0010, 1'b1, 8'h13, 1'b1, 8'h13, 1'b0, 1'b1}  // R9 held, R8 flow off
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {ins_view(), fwd_vld, tx_pause, spec_irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      @(negedge clk);
      fc_mode = v[23:20];
      spec_en = v[19];
      rx_byte = v[18:11];
      rx_vld  = 1'b1;
      @(negedge clk); rx_vld = 1'b0;
      chk($sformatf("R%0d table %0d", v[27:24], i),
          {rx_view()[9:0], spec_irq}, {v[10:1], v[0]});
    end

    // R9 clear, then clear and match together
    spec_en = 1'b0;
    @(negedge clk); spec_clr = 1'b1;
    @(negedge clk); spec_clr = 1'b0;
    chk("R9 clear", {31'd0, spec_irq}, 32'd0);
    spec_en = 1'b1;
    send(8'h55);
    chk("R8 no match", {31'd0, spec_irq}, 32'd0);
    @(negedge clk); rx_byte = C_OFF2; rx_vld = 1'b1; spec_clr = 1'b1;
    @(negedge clk); rx_vld = 1'b0; spec_clr = 1'b0;
    chk("R9 set wins", {31'd0, spec_irq}, 32'd1);
    spec_en = 1'b0;
    @(negedge clk); spec_clr = 1'b1;
    @(negedge clk); spec_clr = 1'b0;

    // R6 broken pairs in dual mode
    fc_mode = 4'b1011;
    send(C_OFF1);
    chk("R6 pending held", rx_view(), {22'd0, 1'b0, 8'h00, 1'b0});
    send(8'h55);
    chk("R6 pending out", rx_view(), {22'd0, 1'b1, C_OFF1, 1'b0});
    @(negedge clk);
    chk("R6 new byte next", rx_view(), {22'd0, 1'b1, 8'h55, 1'b0});
    send(C_OFF1); send(C_OFF2);
    chk("R5 pause", rx_view(), {22'd0, 1'b0, 8'h00, 1'b1});
    send(C_OFF1); send(C_ON1);
    chk("R6 replaced pending", rx_view(), {22'd0, 1'b1, C_OFF1, 1'b1});
    @(negedge clk);
    chk("R6 no second byte", rx_view(), {22'd0, 1'b0, 8'h00, 1'b1});
    send(C_ON2);
    chk("R6 new pair completes", rx_view(), {22'd0, 1'b0, 8'h00, 1'b0});

    // R10 threshold requests
    fc_mode = 4'b1000;
    @(negedge clk); rxq_level = 5'd11;
    @(negedge clk);
    chk("R10 below hi", ins_view(), 32'h0);
    rxq_level = 5'd12;
    @(negedge clk);
    chk("R10 xoff req", ins_view(), {28'd0, 1'b1, 1'b1, 2'b10});
    @(negedge clk);
    chk("R10 one shot", ins_view(), 32'h0);
    rxq_level = 5'd5;
    @(negedge clk);
    chk("R10 above lo", ins_view(), 32'h0);
    rxq_level = 5'd4;
    @(negedge clk);
    chk("R10 xon req", ins_view(), {28'd0, 1'b1, 1'b0, 2'b10});
    @(negedge clk);
    chk("R10 xon one shot", ins_view(), 32'h0);
    fc_mode = 4'b1100; rxq_level = 5'd13;
    @(negedge clk);
    chk("R10 both pairs", ins_view(), {28'd0, 1'b1, 1'b1, 2'b11});
    rxq_level = 5'd2;
    @(negedge clk);
    chk("R10 both xon", ins_view(), {28'd0, 1'b1, 1'b0, 2'b11});
    fc_mode = 4'b0000; rxq_level = 5'd15;
    @(negedge clk);
    chk("R10 tx none", ins_view(), 32'h0);
    @(negedge clk);
    chk("R10 tx none held", ins_view(), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule